// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte-Lane Writes

This block models a synchronous static memory of 18-bit words. Address, write data and every control input except the output enable are captured in registers on the rising clock edge. An access then runs from those registered values. Writes complete inside the block on the next edge, and read data is registered and driven onto a shared bidirectional data port. All control inputs are active high.

A burst opens from either of two address strobes: one meant for a processor, one for a cache controller. The registered address becomes the burst base. Later cycles of the burst reuse that base. The two lowest address bits are replaced by the base's low bits XOR a 2-bit beat counter, and the counter steps only on cycles where the advance input is high. Each word is split into two 9-bit lanes with separate write enables. The address width is a parameter, so the array can be kept small in simulation.

Top module: `sync_burst_sram`

## Requirements
- R1: A synchronous reset ends any burst and clears the read-valid state, so the data port floats until a read completes; non-start cycles after reset cause no access.
- R2: Inputs are sampled on the rising edge. Read data for an access whose address was sampled at edge N is driven after edge N+1 and stays until the next access edge.
- R3: The data port is driven only while out_en is high and the output register holds read data. out_en acts without a clock edge.
- R4: ads_cpu high with chip_en high starts a burst at the sampled address. That cycle is always a read, whatever the write enables are, and ads_cpu takes priority over ads_ctl.
- R5: ads_cpu with chip_en low is ignored. The cycle is handled exactly as if ads_cpu were low.
- R6: ads_ctl high with chip_en high starts a burst at the sampled address, as a write if either lane enable is high and as a read otherwise. ads_ctl high with chip_en low deselects: there is no access, the port floats and the burst ends.
- R7: On a non-start cycle of an open burst with adv high, the beat count steps by one modulo 4. The accessed address keeps the base's upper bits, and its low two bits equal the base's low two bits XOR the count (interleaved order, wrapping after four beats).
- R8: On a non-start cycle of an open burst with adv low, the previous address is accessed again, as a read or a write according to the lane enables.
- R9: we_lo writes data bits 8:0 and we_hi writes bits 17:9. Either lane may be written alone, leaving the other lane unchanged, or both together.
- R10: A write completes internally: a read sampled on the edge after a write sampled to the same address returns the new data, and the port is not driven in the cycle after a write access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs except out_en are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| ads_cpu | input | 1 | Processor address strobe (read-only burst start) |
| ads_ctl | input | 1 | Controller address strobe (read or write burst start) |
| adv | input | 1 | Burst advance |
| chip_en | input | 1 | Chip enable |
| we_lo | input | 1 | Write enable for bits 8:0 |
| we_hi | input | 1 | Write enable for bits 17:9 |
| out_en | input | 1 | Asynchronous output enable |
| dq | inout | 18 | Shared write-data input and read-data output |

## Verification
The bench goes after the burst sequence at a base that is not aligned to four beats, where a linear counter would yield 6,7,8,9 instead of 6,7,4,5, and after the wrap on the fifth beat, which a counter wider than two bits would carry into the upper address. It drives write enables together with a processor start, where a design that honoured them would overwrite memory, and a processor start with chip enable low inside an open burst, where a design that did not ignore it would restart the burst at a new address. Single-lane writes catch a lane swap or a whole-word write. A read placed on the edge right after a write catches a design that completes writes a cycle late. Toggling the output enable in mid-cycle catches an output enable that waits for a clock edge.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int WORD_W  = 18;
    localparam int LANE_W  = 9;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic             cpu_strobe;
        logic             ctl_strobe;
        logic             advance;
        logic             chip_en;
        logic [LANES-1:0] lane_we;
    } ctrl_t;

    function automatic logic [BURST_W-1:0] beat_low(
        input logic [BURST_W-1:0] base_low,
        input logic [BURST_W-1:0] count
    );
        return base_low ^ count;
    endfunction

endpackage

// File: rtl/sbs_in_reg.sv
module sbs_in_reg
    import sbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] data_i,
    output ctrl_t             ctrl_q,
    output logic [AW-1:0]     addr_q,
    output logic [WORD_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_i;
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_q,
    input  logic [AW-1:0]    addr_q,
    output acc_kind_e        acc_kind,
    output logic             acc_start,
    output logic [AW-1:0]    acc_addr,
    output logic [LANES-1:0] acc_lane_we
);

    localparam int HI_W = AW - BURST_W;

    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               open_q;

    logic               cpu_go;
    logic               ctl_go;
    logic               desel;
    logic               cont;
    logic               any_we;
    logic [BURST_W-1:0] cnt_nx;

    always_comb begin
        any_we = |ctrl_q.lane_we;
        cpu_go = ctrl_q.cpu_strobe & ctrl_q.chip_en;
        ctl_go = ~cpu_go & ctrl_q.ctl_strobe & ctrl_q.chip_en;
        desel  = ~cpu_go & ctrl_q.ctl_strobe & ~ctrl_q.chip_en;
        cont   = ~cpu_go & ~ctrl_q.ctl_strobe & open_q;
        cnt_nx = ctrl_q.advance ? cnt_q + BURST_W'(1) : cnt_q;
    end

    always_comb begin
        acc_start   = cpu_go | ctl_go;
        acc_kind    = ACC_NONE;
        acc_addr    = addr_q;
        acc_lane_we = '0;
        if (cpu_go) begin
            acc_kind = ACC_READ;
        end else if (ctl_go) begin
            acc_kind    = any_we ? ACC_WRITE : ACC_READ;
            acc_lane_we = ctrl_q.lane_we;
        end else if (cont) begin
            acc_kind    = any_we ? ACC_WRITE : ACC_READ;
            acc_lane_we = ctrl_q.lane_we;
            acc_addr    = {base_q[AW-1 -: HI_W],
                           beat_low(base_q[BURST_W-1:0], cnt_nx)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            open_q <= 1'b0;
        end else if (acc_start) begin
            base_q <= addr_q;
            cnt_q  <= '0;
            open_q <= 1'b1;
        end else if (desel) begin
            open_q <= 1'b0;
        end else if (cont) begin
            cnt_q <= cnt_nx;
        end
    end

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array
    import sbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         acc_kind,
    input  logic [AW-1:0]     acc_addr,
    input  logic [LANES-1:0]  acc_lane_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata_q,
    output logic              rvalid_q
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (acc_kind == ACC_WRITE && acc_lane_we[g]) begin
                mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (acc_kind == ACC_READ) begin
                rdata_q[g*LANE_W +: LANE_W] <= mem[acc_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= (acc_kind == ACC_READ);
        end
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ads_cpu,
    input  logic              ads_ctl,
    input  logic              adv,
    input  logic              chip_en,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic              out_en,
    inout  wire  [WORD_W-1:0] dq
);

    ctrl_t              ctrl_in;
    ctrl_t              ctrl_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  data_q;
    acc_kind_e          acc_kind;
    logic               acc_start;
    logic [ADDR_W-1:0]  acc_addr;
    logic [LANES-1:0]   acc_lane_we;
    logic [WORD_W-1:0]  rdata_q;
    logic               rvalid_q;
    logic               adv_q;

    always_comb begin
        ctrl_in.cpu_strobe = ads_cpu;
        ctrl_in.ctl_strobe = ads_ctl;
        ctrl_in.advance    = adv;
        ctrl_in.chip_en    = chip_en;
        ctrl_in.lane_we    = {we_hi, we_lo};
        adv_q              = ctrl_q.advance;
    end

    sbs_in_reg #(.AW(ADDR_W)) u_in_reg (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl_in),
        .addr_i (addr),
        .data_i (dq),
        .ctrl_q (ctrl_q),
        .addr_q (addr_q),
        .data_q (data_q)
    );

    sbs_burst_seq #(.AW(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctrl_q      (ctrl_q),
        .addr_q      (addr_q),
        .acc_kind    (acc_kind),
        .acc_start   (acc_start),
        .acc_addr    (acc_addr),
        .acc_lane_we (acc_lane_we)
    );

    sbs_lane_array #(.AW(ADDR_W)) u_array (
        .clk         (clk),
        .rst         (rst),
        .acc_kind    (acc_kind),
        .acc_addr    (acc_addr),
        .acc_lane_we (acc_lane_we),
        .wdata       (data_q),
        .rdata_q     (rdata_q),
        .rvalid_q    (rvalid_q)
    );

    assign dq = (out_en && rvalid_q) ? rdata_q : {WORD_W{1'bz}};

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
    import sbs_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ads_cpu,
    input logic          ads_ctl,
    input logic          chip_en,
    input acc_kind_e     acc_kind,
    input logic          acc_start,
    input logic [AW-1:0] acc_addr,
    input logic          adv_q,
    input logic          rvalid_q
);

    logic cont_acc;
    assign cont_acc = (acc_kind != ACC_NONE) && !acc_start;

    assert_cpu_start_read_R4: assert property (@(posedge clk) disable iff (rst)
        (ads_cpu && chip_en) |=> (acc_kind == ACC_READ && acc_start));

    assert_ctl_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        (ads_ctl && !chip_en) |=> (acc_kind == ACC_NONE));

    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (cont_acc && !adv_q) |-> (acc_addr == $past(acc_addr)));

    assert_burst_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        cont_acc |-> (acc_addr[AW-1:BURST_W] == $past(acc_addr[AW-1:BURST_W])));

    assert_burst_step_R7: assert property (@(posedge clk) disable iff (rst)
        (cont_acc && adv_q) |-> (acc_addr[BURST_W-1:0] != $past(acc_addr[BURST_W-1:0])));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == ACC_READ) |=> rvalid_q);

    assert_write_float_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_kind != ACC_READ) |=> !rvalid_q);

endmodule

bind sync_burst_sram sbs_checker #(.AW(ADDR_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .ads_cpu   (ads_cpu),
    .ads_ctl   (ads_ctl),
    .chip_en   (chip_en),
    .acc_kind  (acc_kind),
    .acc_start (acc_start),
    .acc_addr  (acc_addr),
    .adv_q     (adv_q),
    .rvalid_q  (rvalid_q)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam logic [17:0] FLOAT = 18'h3FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ads_cpu = 1'b0, ads_ctl = 1'b0, adv = 1'b0, chip_en = 1'b0;
    logic          we_lo = 1'b0, we_hi = 1'b0, out_en = 1'b0;
    logic          tb_drive = 1'b0;
    logic [17:0]   tb_dq = '0;
    wire  [17:0]   dq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    assign dq = tb_drive ? tb_dq : 18'bz;
    for (genvar i = 0; i < 18; i++) begin : g_pull
        pullup (dq[i]);
    end

    sync_burst_sram #(.ADDR_W(AW)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .addr(addr), .ads_cpu(ads_cpu), .ads_ctl(ads_ctl),
        .adv(adv), .chip_en(chip_en), .we_lo(we_lo), .we_hi(we_hi),
        .out_en(out_en), .dq(dq)
    );

    // Behavioural reference model
    logic [17:0] m_mem [DEPTH];
    bit          m_open = 0, m_valid = 0;
    int          m_base = 0, m_cnt = 0;
    logic [17:0] m_q = '0;
    bit          r_cpu = 0, r_ctl = 0, r_adv = 0, r_ce = 0;
    bit [1:0]    r_we = '0;
    int          r_addr = 0;
    logic [17:0] r_d = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_open = 0; m_valid = 0; m_cnt = 0;
            r_cpu = 0; r_ctl = 0; r_adv = 0; r_ce = 0; r_we = '0; r_addr = 0;
        end else begin
            int  a;
            bit  acc, wr;
            acc = 0; wr = 0; a = 0;
            if (r_cpu && r_ce) begin
                acc = 1; wr = 0; a = r_addr; m_base = r_addr; m_cnt = 0; m_open = 1;
            end else if (r_ctl && r_ce) begin
                acc = 1; wr = (r_we != 0); a = r_addr; m_base = r_addr; m_cnt = 0; m_open = 1;
            end else if (r_ctl) begin
                m_open = 0;
            end else if (m_open) begin
                if (r_adv) m_cnt = (m_cnt + 1) % 4;
                acc = 1; wr = (r_we != 0);
                a = (m_base & ~3) | ((m_base ^ m_cnt) & 3);
            end
            if (acc && wr) begin
                if (r_we[0]) m_mem[a][8:0]  = r_d[8:0];
                if (r_we[1]) m_mem[a][17:9] = r_d[17:9];
                m_valid = 0;
            end else if (acc) begin
                m_q = m_mem[a]; m_valid = 1;
            end else begin
                m_valid = 0;
            end
            r_cpu = ads_cpu; r_ctl = ads_ctl; r_adv = adv; r_ce = chip_en;
            r_we = {we_hi, we_lo}; r_addr = int'(addr); r_d = tb_drive ? tb_dq : FLOAT;
        end
    end

    task automatic check_port(input string tag);
        logic [17:0] exp;
        exp = (out_en && m_valid) ? m_q : FLOAT;
        n_checks++;
        if (dq !== exp) begin
            n_fail++;
            $display("FAIL %s dq=%h expected=%h at %0t", tag, dq, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, compare 1 ns later, wait for next negedge
    task automatic step(input string tag, input bit cpu, input bit ctl, input bit av,
                        input bit ce, input bit [1:0] we, input int a,
                        input logic [17:0] d, input bit oe);
        ads_cpu = cpu; ads_ctl = ctl; adv = av; chip_en = ce;
        we_lo = we[0]; we_hi = we[1]; addr = AW'(a);
        tb_drive = (we != 0); tb_dq = d;
        out_en = tb_drive ? 1'b0 : oe;
        #1;
        if (!tb_drive) check_port(tag);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int k = 0; k < n; k++) step(tag, 0, 0, 0, 0, 2'b00, 0, '0, 1);
    endtask

    function automatic logic [17:0] pat(input int a);
        return 18'((a * 18'h0A5 + 18'h137) & 18'h1FFFF);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R1: reset state, port floats with output enable high
        step("R1", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        rst = 1'b0;
        idle("R1", 3);

        // R6: controller-strobe write start fills the array
        for (int a = 0; a < DEPTH; a++) step("R6", 0, 1, 0, 1, 2'b11, a, pat(a), 0);
        idle("R10", 2);

        // R2: processor-strobe read with one cycle latency, then hold
        step("R2", 1, 0, 0, 1, 2'b00, 5, '0, 1);
        step("R2", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        step("R2", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        // R8: open burst without advance keeps reading the same word
        step("R8", 0, 0, 0, 0, 2'b00, 0, '0, 1);

        // R7: interleaved burst from unaligned base 6 -> 6,7,4,5,6
        step("R7", 1, 0, 0, 1, 2'b00, 6, '0, 1);
        for (int k = 0; k < 5; k++) step("R7", 0, 0, 1, 1, 2'b00, 0, '0, 1);
        step("R8", 0, 0, 0, 1, 2'b00, 0, '0, 1);
        step("R8", 0, 0, 0, 1, 2'b00, 0, '0, 1);

        // R3: output enable acts without a clock edge
        out_en = 1'b0; #0.5; check_port("R3");
        out_en = 1'b1; #0.5; check_port("R3");
        @(negedge clk);

        // R4: write enables ignored on a processor start, and priority over controller
        step("R4", 1, 0, 0, 1, 2'b11, 9, 18'h00F0F, 0);
        step("R4", 1, 1, 0, 1, 2'b11, 12, 18'h01234, 0);
        step("R4", 0, 1, 0, 0, 2'b00, 0, '0, 1);
        step("R4", 0, 1, 0, 1, 2'b00, 9, '0, 1);
        step("R4", 0, 1, 0, 1, 2'b00, 12, '0, 1);
        step("R4", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        step("R4", 0, 0, 0, 0, 2'b00, 0, '0, 1);

        // R5: processor strobe with chip enable low inside a burst is ignored
        step("R5", 0, 1, 0, 1, 2'b00, 17, '0, 1);
        step("R5", 1, 0, 1, 0, 2'b00, 40, '0, 1);
        step("R5", 1, 0, 1, 0, 2'b00, 40, '0, 1);
        step("R5", 0, 0, 0, 0, 2'b00, 0, '0, 1);

        // R6: deselect ends the burst, later cycles do nothing
        step("R6", 0, 1, 0, 0, 2'b00, 0, '0, 1);
        step("R6", 0, 0, 1, 0, 2'b00, 0, '0, 1);
        step("R6", 0, 0, 1, 1, 2'b00, 0, '0, 1);
        step("R5", 1, 0, 0, 0, 2'b00, 3, '0, 1);
        step("R5", 0, 0, 0, 0, 2'b00, 0, '0, 1);

        // R9: single-lane writes
        step("R9", 0, 1, 0, 1, 2'b01, 10, 18'h155AA, 0);
        step("R9", 0, 1, 0, 1, 2'b10, 11, 18'h0AA55, 0);
        step("R9", 0, 1, 0, 1, 2'b00, 10, '0, 1);
        step("R9", 0, 1, 0, 1, 2'b00, 11, '0, 1);
        step("R9", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        step("R9", 0, 0, 0, 0, 2'b00, 0, '0, 1);

        // R10: write then read on the very next edge; port floats after write
        step("R10", 0, 1, 0, 1, 2'b11, 20, 18'h12345, 0);
        step("R10", 0, 1, 0, 1, 2'b00, 20, '0, 1);
        step("R10", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        step("R10", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        // burst writes through advance cycles, then interleaved read back
        step("R7", 0, 1, 0, 1, 2'b11, 33, 18'h00111, 0);
        step("R7", 0, 0, 1, 1, 2'b11, 0, 18'h00222, 0);
        step("R7", 0, 0, 1, 1, 2'b11, 0, 18'h00333, 0);
        step("R7", 0, 0, 1, 1, 2'b11, 0, 18'h00444, 0);
        step("R10", 0, 0, 0, 1, 2'b00, 0, '0, 1);
        step("R7", 1, 0, 0, 1, 2'b00, 33, '0, 1);
        for (int k = 0; k < 4; k++) step("R7", 0, 0, 1, 1, 2'b00, 0, '0, 1);
        step("R7", 0, 0, 0, 1, 2'b00, 0, '0, 1);

        // R1: reset in mid-burst closes it
        step("R1", 1, 0, 0, 1, 2'b00, 2, '0, 1);
        rst = 1'b1;
        step("R1", 0, 0, 0, 0, 2'b00, 0, '0, 1);
        rst = 1'b0;
        step("R1", 0, 0, 1, 1, 2'b00, 0, '0, 1);
        idle("R1", 3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule